// File: doc/BRIEF.md
# Serial Stop-Clock Control Register

This block takes a serial control word that an external sender shifts in on a single data line and turns it into one run-enable flag per controllable clock output. The word is clocked by the bus clock. The sender changes the data line on the rising edge, and the block samples it on the falling edge. The line idles high. A frame begins when the line is sampled low once; this is the start bit. Fifteen data bits follow, one per falling edge, and the next falling edge commits the whole word at once. A one keeps its output running, and a zero asks for that output to be stopped low.

The received bits collect in a shadow register. The active enable register changes only on the commit edge, so a partial frame never reaches the outputs. Two positions in the frame carry no output and are dropped. A downstream gating stage consumes the enables. The block runs on one state machine with three states. ST_IDLE waits for a start bit. ST_SHIFT takes the data bits. ST_COMMIT loads the active register. The transitions are named as follows. T_START goes from ST_IDLE to ST_SHIFT when a low is sampled. T_LAST goes from ST_SHIFT to ST_COMMIT when the fifteenth data bit is sampled. T_DONE goes from ST_COMMIT back to ST_IDLE unconditionally. ST_IDLE stays in ST_IDLE while the line is high, and ST_SHIFT stays in ST_SHIFT until the last bit.

Top module: `stopclk_serial_ctrl`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, every bit of run_en is 1 and busy is 0.
- R2: While idle, a high sample of sdata_in on a falling edge of clk_bus starts nothing: busy stays 0 and run_en keeps its value.
- R3: While idle, a low sample of sdata_in on a falling edge (the start bit) makes busy 1 from that edge on.
- R4: After the start edge, exactly 15 falling edges sample data bits and the 16th falling edge commits. busy is 1 for exactly those 16 edges and returns to 0 on the commit edge.
- R5: run_en changes only on the commit edge. During a frame it holds its previous value.
- R6: Frame bit n (n = 1 for the first data bit after the start bit) maps onto run_en as follows. n=1 goes to run_en[12] (graphics clock). n=3 goes to run_en[11] (floppy clock). n=4..10 go to run_en[4+(10-n)], bus clocks 6 down to 0. n=12..15 go to run_en[15-n], processor clocks 3 down to 0. A 1 bit sets the enable to 1 (run) and a 0 bit clears it to 0 (stop low).
- R7: Frame bits 2 and 11 are received but have no effect on any run_en bit.
- R8: The value of sdata_in on the commit edge is ignored: a low there does not start a new frame, and busy is 0 after that edge.
- R9: An assertion of reset in the middle of a frame discards the partial frame. The next frame after reset is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Bus clock. Its falling edge samples the data line and updates all state. |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_in | input | 1 | Serial control data, idles high |
| run_en | output | 13 | Registered run-enable per controllable clock (1 = run) |
| busy | output | 1 | High from the start-bit edge until the commit edge |

## Verification
The bench goes after the frame length first. If the bit counter is off by one, the design commits a word that is shifted by one position, and busy drops one edge early or late. A machine that commits on the last data edge instead of on its own extra edge, or that copies the shadow register live, moves run_en in the middle of the frame. The bench also drives a low on the commit edge: a design that treats that edge as idle would restart and hold busy high. Frames that differ only in the two spare positions catch a spare bit leaking into an enable. A reset in the middle of a frame, followed by a full frame, catches a counter or state machine that survives reset.

// File: rtl/sscr_pkg.sv
package sscr_pkg;

    // Receiver sequencing states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } sscr_state_e;

    // Number of frame positions that carry no output
    localparam int SPARE_SLOTS = 2;
    // Number of single fixed-frequency clocks under control (graphics, floppy)
    localparam int FIXED_SLOTS = 2;

endpackage

// File: rtl/sscr_fsm.sv
module sscr_fsm
    import sscr_pkg::*;
(
    input  logic clk_bus,
    input  logic rst_n,
    input  logic sdata_in,
    input  logic last_bit,
    output logic busy,
    output logic shift_en,
    output logic commit_en,
    output logic cnt_clr
);

    sscr_state_e state_q;
    sscr_state_e state_d;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!sdata_in) begin
                    state_d = ST_SHIFT;       // T_START
                end
            end
            ST_SHIFT: begin
                if (last_bit) begin
                    state_d = ST_COMMIT;      // T_LAST
                end
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;            // T_DONE
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register, sampled on the falling bus-clock edge
    always_ff @(negedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        busy      = 1'b0;
        shift_en  = 1'b0;
        commit_en = 1'b0;
        cnt_clr   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_SHIFT: begin
                busy     = 1'b1;
                shift_en = 1'b1;
                cnt_clr  = 1'b0;
            end
            ST_COMMIT: begin
                busy      = 1'b1;
                commit_en = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sscr_bit_counter.sv
module sscr_bit_counter #(
    parameter int FRAME_W = 15,
    localparam int CNT_W  = (FRAME_W > 1) ? $clog2(FRAME_W) : 1
) (
    input  logic clk_bus,
    input  logic rst_n,
    input  logic cnt_clr,
    input  logic cnt_en,
    output logic last_bit
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(negedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_clr) begin
            cnt_q <= '0;
        end else if (cnt_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Asserted during the interval whose closing edge samples the final data bit
    assign last_bit = cnt_en && (cnt_q == LAST_IDX);

endmodule

// File: rtl/sscr_shifter.sv
module sscr_shifter #(
    parameter int FRAME_W = 15
) (
    input  logic               clk_bus,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               sdata_in,
    output logic [FRAME_W-1:0] shadow
);

    // The first data bit travels to the top; the last one stays at index 0
    always_ff @(negedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '1;
        end else if (shift_en) begin
            shadow <= {shadow[FRAME_W-2:0], sdata_in};
        end
    end

endmodule

// File: rtl/sscr_commit.sv
module sscr_commit #(
    parameter int PROC_CLKS = 4,
    parameter int BUS_CLKS  = 7,
    localparam int FRAME_W  = PROC_CLKS + BUS_CLKS + sscr_pkg::SPARE_SLOTS + sscr_pkg::FIXED_SLOTS,
    localparam int RUN_W    = PROC_CLKS + BUS_CLKS + sscr_pkg::FIXED_SLOTS
) (
    input  logic               clk_bus,
    input  logic               rst_n,
    input  logic               commit_en,
    input  logic [FRAME_W-1:0] shadow,
    output logic [RUN_W-1:0]   run_en
);

    // Shadow layout (index 0 = last bit received):
    //   [PROC_CLKS-1:0]                     processor clocks, index = clock number
    //   [PROC_CLKS]                         spare
    //   [PROC_CLKS+1 +: BUS_CLKS]           bus clocks, offset = clock number
    //   [PROC_CLKS+BUS_CLKS+1]              floppy clock
    //   [PROC_CLKS+BUS_CLKS+2]              spare
    //   [PROC_CLKS+BUS_CLKS+3]              graphics clock
    localparam int BUS_BASE   = PROC_CLKS + 1;
    localparam int FLOPPY_IDX = PROC_CLKS + BUS_CLKS + 1;
    localparam int SPARE_HI   = PROC_CLKS + BUS_CLKS + 2;
    localparam int GFX_IDX    = PROC_CLKS + BUS_CLKS + 3;

    logic [RUN_W-1:0] mapped;
    logic             spare_unused;

    for (genvar p = 0; p < PROC_CLKS; p++) begin : g_proc
        assign mapped[p] = shadow[p];
    end

    for (genvar b = 0; b < BUS_CLKS; b++) begin : g_bus
        assign mapped[PROC_CLKS + b] = shadow[BUS_BASE + b];
    end

    assign mapped[PROC_CLKS + BUS_CLKS]     = shadow[FLOPPY_IDX];
    assign mapped[PROC_CLKS + BUS_CLKS + 1] = shadow[GFX_IDX];

    // Spare positions are received and dropped here
    assign spare_unused = shadow[PROC_CLKS] ^ shadow[SPARE_HI];

    always_ff @(negedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            run_en <= '1;
        end else if (commit_en) begin
            run_en <= mapped;
        end
    end

endmodule

// File: rtl/stopclk_serial_ctrl.sv
module stopclk_serial_ctrl #(
    parameter int PROC_CLKS = 4,
    parameter int BUS_CLKS  = 7,
    localparam int FRAME_W  = PROC_CLKS + BUS_CLKS + sscr_pkg::SPARE_SLOTS + sscr_pkg::FIXED_SLOTS,
    localparam int RUN_W    = PROC_CLKS + BUS_CLKS + sscr_pkg::FIXED_SLOTS
) (
    input  logic             clk_bus,
    input  logic             rst_n,
    input  logic             sdata_in,
    output logic [RUN_W-1:0] run_en,
    output logic             busy
);

    logic               last_bit;
    logic               shift_en;
    logic               commit_en;
    logic               cnt_clr;
    logic [FRAME_W-1:0] shadow;

    sscr_fsm u_fsm (
        .clk_bus   (clk_bus),
        .rst_n     (rst_n),
        .sdata_in  (sdata_in),
        .last_bit  (last_bit),
        .busy      (busy),
        .shift_en  (shift_en),
        .commit_en (commit_en),
        .cnt_clr   (cnt_clr)
    );

    sscr_bit_counter #(
        .FRAME_W (FRAME_W)
    ) u_cnt (
        .clk_bus  (clk_bus),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .cnt_en   (shift_en),
        .last_bit (last_bit)
    );

    sscr_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk_bus  (clk_bus),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdata_in (sdata_in),
        .shadow   (shadow)
    );

    sscr_commit #(
        .PROC_CLKS (PROC_CLKS),
        .BUS_CLKS  (BUS_CLKS)
    ) u_commit (
        .clk_bus   (clk_bus),
        .rst_n     (rst_n),
        .commit_en (commit_en),
        .shadow    (shadow),
        .run_en    (run_en)
    );

endmodule

// File: rtl/sscr_checker.sv
module sscr_checker #(
    parameter int PROC_CLKS = 4,
    parameter int BUS_CLKS  = 7,
    localparam int FRAME_W  = PROC_CLKS + BUS_CLKS + sscr_pkg::SPARE_SLOTS + sscr_pkg::FIXED_SLOTS,
    localparam int RUN_W    = PROC_CLKS + BUS_CLKS + sscr_pkg::FIXED_SLOTS,
    localparam int LEN_W    = $clog2(FRAME_W + 3)
) (
    input logic             clk_bus,
    input logic             rst_n,
    input logic             sdata_in,
    input logic [RUN_W-1:0] run_en,
    input logic             busy
);

    localparam logic [LEN_W-1:0] FRAME_EDGES = LEN_W'(FRAME_W + 1);

    // Consecutive falling edges that sampled busy high
    logic [LEN_W-1:0] busy_len;

    always_ff @(negedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (busy) begin
            busy_len <= busy_len + 1'b1;
        end else begin
            busy_len <= '0;
        end
    end

    // R2
    idle_hold_chk: assert property (@(negedge clk_bus) disable iff (!rst_n)
        (!busy && sdata_in) |=> !busy);

    // R3
    start_detect_chk: assert property (@(negedge clk_bus) disable iff (!rst_n)
        (!busy && !sdata_in) |=> busy);

    // R4
    frame_len_chk: assert property (@(negedge clk_bus) disable iff (!rst_n)
        busy |-> (busy_len < FRAME_EDGES));

    // R4
    frame_end_chk: assert property (@(negedge clk_bus) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == FRAME_EDGES));

    // R5
    hold_while_shift_chk: assert property (@(negedge clk_bus) disable iff (!rst_n)
        !$stable(run_en) |-> $fell(busy));

endmodule

bind stopclk_serial_ctrl sscr_checker #(
    .PROC_CLKS (PROC_CLKS),
    .BUS_CLKS  (BUS_CLKS)
) u_sscr_checker (
    .clk_bus  (clk_bus),
    .rst_n    (rst_n),
    .sdata_in (sdata_in),
    .run_en   (run_en),
    .busy     (busy)
);

// File: tb/test_stopclk_serial_ctrl.sv
module test_stopclk_serial_ctrl;

    localparam int FW = 15;
    localparam int RW = 13;
    localparam int NVEC = 6;

    // Frame words: bit [FW-n] holds frame bit n (n=1 sent first)
    localparam logic [FW-1:0] FRAMES [NVEC] = '{
        15'h0000, 15'h7FFF, 15'h5555, 15'h2AAA, 15'h4000, 15'h000F
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sdata = 1'b1;
    logic [RW-1:0] run_en;
    logic          busy;

    int checks = 0;
    int errors = 0;
    logic [RW-1:0] model_run = '1;

    always #2 clk = ~clk;

    stopclk_serial_ctrl i_stopclk_serial_ctrl (
        .clk_bus  (clk),
        .rst_n    (rst_n),
        .sdata_in (sdata),
        .run_en   (run_en),
        .busy     (busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected enables from frame bit positions (R6, R7)
    function automatic logic [RW-1:0] exp_map(input logic [FW-1:0] fr);
        logic [RW-1:0] r;
        r = '0;
        for (int n = 1; n <= FW; n++) begin
            logic b;
            b = fr[FW-n];
            if (n == 1)                 r[12] = b;
            else if (n == 3)            r[11] = b;
            else if (n >= 4 && n <= 10) r[4 + (10 - n)] = b;
            else if (n >= 12)           r[15 - n] = b;
        end
        return r;
    endfunction

    task automatic send_frame(input logic [FW-1:0] fr, input logic commit_val);
        logic [RW-1:0] exp;
        exp = exp_map(fr);
        @(posedge clk); sdata <= 1'b0;              // start bit
        for (int i = 1; i <= FW; i++) begin
            @(posedge clk); sdata <= fr[FW-i];
            if (i == 1) begin
                #1 check("R3 busy after start", 32'(busy), 32'd1);
            end
            if (i == 9) begin
                #1 check("R5 run_en held mid-frame", 32'(run_en), 32'(model_run));
            end
        end
        @(posedge clk); sdata <= commit_val;        // commit clock
        #1 check("R4 busy before commit edge", 32'(busy), 32'd1);
        check("R5 run_en held before commit", 32'(run_en), 32'(model_run));
        @(posedge clk); sdata <= 1'b1;
        #1 check("R4 busy cleared by commit", 32'(busy), 32'd0);
        check("R6 committed run_en", 32'(run_en), 32'(exp));
        model_run = exp;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset values
        repeat (3) @(posedge clk);
        #1 check("R1 run_en in reset", 32'(run_en), 32'h1FFF);
        check("R1 busy in reset", 32'(busy), 32'd0);
        @(posedge clk); rst_n <= 1'b1;

        // R2: idle line high starts nothing
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(posedge clk); #1 if (busy) seen++;
            end
            check("R2 no frame on idle line", 32'(seen), 32'd0);
            check("R2 run_en unchanged idle", 32'(run_en), 32'h1FFF);
        end

        // Table of frames
        for (int v = 0; v < NVEC; v++) begin
            send_frame(FRAMES[v], 1'b1);
        end

        // R7: spare positions have no effect
        send_frame(15'h0000, 1'b1);
        send_frame(15'h7FFF & ~15'h2010, 1'b1);
        check("R7 spares low, all run", 32'(run_en), 32'h1FFF);
        send_frame(15'h2010, 1'b1);
        check("R7 spares high, all stopped", 32'(run_en), 32'h0000);

        // R8: low on the commit edge does not restart
        send_frame(15'h1234, 1'b0);
        @(posedge clk); #1 check("R8 no restart after commit", 32'(busy), 32'd0);
        check("R8 run_en kept", 32'(run_en), 32'(model_run));

        // R9: reset mid-frame discards partial data
        send_frame(15'h0000, 1'b1);
        @(posedge clk); sdata <= 1'b0;
        for (int i = 0; i < 7; i++) begin
            @(posedge clk); sdata <= 1'b1;
        end
        #1 check("R9 busy mid-frame", 32'(busy), 32'd1);
        rst_n = 1'b0;
        #1 check("R9 run_en after abort", 32'(run_en), 32'h1FFF);
        check("R9 busy after abort", 32'(busy), 32'd0);
        model_run = '1;
        @(posedge clk); @(posedge clk); rst_n <= 1'b1;
        send_frame(15'h5A5A, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule